// File: doc/BRIEF.md
# Card Activation and Answer Window Sequencer

This block brings a contact card from unpowered to operational and back again. When a card is present and an activation request arrives, it switches on the card supply. It then connects the I/O contact in receive mode and starts the card clock. It holds the card reset low for a fixed number of card clock ticks and then releases it. After that it watches the receiver's start-bit detector and waits for the card's first character. The host stays in receive mode throughout, so the card is always the first to transmit.

The first start edge is judged against a window counted in card clock ticks from the release of reset. An edge that comes too soon is flagged. An edge inside the window makes the link active. If no edge arrives before the window closes, the block flags the missing answer and powers the card down. Power-down follows a fixed order with one card clock tick between steps. It is started by that timeout, by an explicit request, or at once when the card is pulled out.

All counts use `clk_tick_i`, which is a one-cycle strobe for each card clock period. Defaults: `RST_HOLD`=40000, `ATR_MIN`=400, `ATR_MAX`=40000.

Top module: `card_act_seq`

## Requirements
- R1: After reset all seven outputs are 0.
- R2: An activation request while `card_present_i` is 0 is ignored, and all outputs stay 0.
- R3: Activation order: `vcc_en_o` rises in the cycle after an accepted `activate_i`. `io_en_o` rises after the next tick. `clk_en_o` rises after the tick after that.
- R4: `rst_o` stays 0 until `RST_HOLD` ticks have been counted with the clock enabled. It rises in the cycle after the `RST_HOLD`-th tick.
- R5: A start edge seen after n ticks since `rst_o` rose, where `ATR_MIN` <= n < `ATR_MAX`, sets `active_o` in the next cycle.
- R6: A start edge with n < `ATR_MIN` sets `early_answer_o` in the next cycle. The block keeps waiting, and a later edge inside the window still sets `active_o`.
- R7: If no legal edge has arrived when the `ATR_MAX`-th tick comes, `no_answer_o` rises and deactivation starts in the next cycle. An edge at n = `ATR_MAX`-1 on that same tick is still legal.
- R8: Deactivation order: first `rst_o` falls. `clk_en_o` falls after the next tick. `io_en_o` falls after the tick after that. `vcc_en_o` falls after one more tick.
- R9: `deactivate_i` while powering up, waiting or active starts deactivation in the next cycle, with `rst_o` and `active_o` low.
- R10: Loss of `card_present_i` in any powered state other than deactivation starts deactivation in the next cycle.
- R11: `no_answer_o` and `early_answer_o` keep their value until the next accepted activation, which clears both in the same cycle that `vcc_en_o` rises.
- R12: Start edges during the reset hold or while active have no effect on any output.
- R13: Activation and deactivation steps advance only in cycles with `clk_tick_i` = 1. Outputs hold in cycles without a tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| card_present_i | input | 1 | Card detected as properly inserted |
| activate_i | input | 1 | One-cycle request to start activation |
| deactivate_i | input | 1 | One-cycle request to power the card down |
| clk_tick_i | input | 1 | Strobe, one cycle per card clock period |
| start_det_i | input | 1 | Start bit detected by the receiver |
| vcc_en_o | output | 1 | Card supply enable |
| io_en_o | output | 1 | I/O contact connected in receive mode |
| clk_en_o | output | 1 | Card clock enable |
| rst_o | output | 1 | Card reset line, high means released |
| active_o | output | 1 | Valid answer start seen, link up |
| no_answer_o | output | 1 | Answer window expired, sticky |
| early_answer_o | output | 1 | Start edge came before the window, sticky |

## Verification
Every output is a register that follows the state. A result therefore shows in the first cycle after the input that caused it: after the request, the tick or the start strobe, or after `card_present_i` drops. The bench applies each stimulus for exactly one edge and samples 1 ns after that edge. It then inserts zero to two idle cycles at random before the next tick and confirms that nothing has moved in between. Window edge positions are drawn at random. The expected outcome is computed from the tick count alone: early, legal or timeout.

// File: rtl/card_act_pkg.sv
package card_act_pkg;
  typedef enum logic [3:0] {
    ST_IDLE,
    ST_PWR,
    ST_IO,
    ST_HOLD,
    ST_ATR,
    ST_ACTIVE,
    ST_D_RST,
    ST_D_CLK,
    ST_D_IO
  } seq_st_e;
endpackage

// File: rtl/card_tick_cnt.sv
module card_tick_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                     cnt_o <= '0;
    else if (clr_i)                  cnt_o <= '0;
    else if (inc_i && cnt_o != '1)   cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/card_atr_judge.sv
module card_atr_judge #(
  parameter int W       = 16,
  parameter int ATR_MIN = 400,
  parameter int ATR_MAX = 40000
) (
  input  logic [W-1:0] cnt_i,
  input  logic         tick_i,
  input  logic         edge_i,
  output logic         early_o,
  output logic         valid_o,
  output logic         timeout_o
);
  localparam logic [W-1:0] MIN_C  = W'(ATR_MIN);
  localparam logic [W-1:0] MAX_C  = W'(ATR_MAX);
  localparam logic [W-1:0] LAST_C = W'(ATR_MAX - 1);

  always_comb begin
    early_o   = edge_i && (cnt_i < MIN_C);
    valid_o   = edge_i && (cnt_i >= MIN_C) && (cnt_i < MAX_C);
    // window closes on the tick that would make the count reach ATR_MAX
    timeout_o = tick_i && (cnt_i == LAST_C) && !valid_o;
  end
endmodule

// File: rtl/card_act_seq.sv
module card_act_seq
  import card_act_pkg::*;
#(
  parameter int RST_HOLD = 40000,
  parameter int ATR_MIN  = 400,
  parameter int ATR_MAX  = 40000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic card_present_i,
  input  logic activate_i,
  input  logic deactivate_i,
  input  logic clk_tick_i,
  input  logic start_det_i,
  output logic vcc_en_o,
  output logic io_en_o,
  output logic clk_en_o,
  output logic rst_o,
  output logic active_o,
  output logic no_answer_o,
  output logic early_answer_o
);
  localparam int CNT_MAX = (RST_HOLD > ATR_MAX) ? RST_HOLD : ATR_MAX;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);
  localparam logic [CNT_W-1:0] HOLD_LAST = CNT_W'(RST_HOLD - 1);

  seq_st_e          st_q, st_d;
  logic [CNT_W-1:0] cnt;
  logic             early_w, valid_w, timeout_w, hold_done, powered_run;

  card_tick_cnt #(.W(CNT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (st_d != st_q),
    .inc_i  (clk_tick_i),
    .cnt_o  (cnt)
  );

  card_atr_judge #(.W(CNT_W), .ATR_MIN(ATR_MIN), .ATR_MAX(ATR_MAX)) u_judge (
    .cnt_i     (cnt),
    .tick_i    (clk_tick_i),
    .edge_i    (start_det_i),
    .early_o   (early_w),
    .valid_o   (valid_w),
    .timeout_o (timeout_w)
  );

  assign hold_done   = clk_tick_i && (cnt == HOLD_LAST);
  assign powered_run = (st_q == ST_PWR) || (st_q == ST_IO) || (st_q == ST_HOLD) ||
                       (st_q == ST_ATR) || (st_q == ST_ACTIVE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:   if (activate_i && card_present_i) st_d = ST_PWR;
      ST_PWR:    if (clk_tick_i) st_d = ST_IO;
      ST_IO:     if (clk_tick_i) st_d = ST_HOLD;
      ST_HOLD:   if (hold_done)  st_d = ST_ATR;
      ST_ATR:    if (valid_w)    st_d = ST_ACTIVE;
                 else if (timeout_w) st_d = ST_D_RST;
      ST_ACTIVE: st_d = ST_ACTIVE;
      ST_D_RST:  if (clk_tick_i) st_d = ST_D_CLK;
      ST_D_CLK:  if (clk_tick_i) st_d = ST_D_IO;
      ST_D_IO:   if (clk_tick_i) st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
    // removal or request overrides any progress
    if (powered_run && (!card_present_i || deactivate_i)) st_d = ST_D_RST;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q           <= ST_IDLE;
      vcc_en_o       <= 1'b0;
      io_en_o        <= 1'b0;
      clk_en_o       <= 1'b0;
      rst_o          <= 1'b0;
      active_o       <= 1'b0;
      no_answer_o    <= 1'b0;
      early_answer_o <= 1'b0;
    end else begin
      st_q <= st_d;
      if (st_d != st_q) begin
        unique case (st_d)
          ST_PWR: begin
            vcc_en_o       <= 1'b1;
            no_answer_o    <= 1'b0;
            early_answer_o <= 1'b0;
          end
          ST_IO:     io_en_o  <= 1'b1;
          ST_HOLD:   clk_en_o <= 1'b1;
          ST_ATR:    rst_o    <= 1'b1;
          ST_ACTIVE: active_o <= 1'b1;
          ST_D_RST: begin
            rst_o    <= 1'b0;
            active_o <= 1'b0;
          end
          ST_D_CLK:  clk_en_o <= 1'b0;
          ST_D_IO:   io_en_o  <= 1'b0;
          ST_IDLE:   vcc_en_o <= 1'b0;
          default: ;
        endcase
      end
      if (st_q == ST_ATR && early_w)   early_answer_o <= 1'b1;
      if (st_q == ST_ATR && timeout_w) no_answer_o    <= 1'b1;
    end
  end
endmodule

// File: rtl/card_act_chk.sv
module card_act_chk #(
  parameter int RST_HOLD = 40000
) (
  input logic clk_i,
  input logic rst_ni,
  input logic card_present_i,
  input logic clk_tick_i,
  input logic vcc_en_o,
  input logic io_en_o,
  input logic clk_en_o,
  input logic rst_o,
  input logic active_o,
  input logic no_answer_o
);
  logic [31:0] hold_cnt;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    hold_cnt <= '0;
    else if (!clk_en_o || rst_o)    hold_cnt <= '0;
    else if (clk_tick_i && hold_cnt != 32'hffff_ffff) hold_cnt <= hold_cnt + 1;
  end

  p_power_card_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vcc_en_o) |-> $past(card_present_i));
  p_io_needs_vcc_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    io_en_o |-> vcc_en_o);
  p_clk_needs_io_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clk_en_o |-> io_en_o);
  p_rst_needs_clk_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_o |-> clk_en_o);
  p_hold_len_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_o) |-> hold_cnt >= RST_HOLD);
  p_active_ok_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_o |-> (rst_o && !no_answer_o));
  p_clk_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(clk_en_o) |-> (!rst_o && !$past(rst_o)));
  p_io_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(io_en_o) |-> (!clk_en_o && !$past(clk_en_o)));
  p_vcc_off_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(vcc_en_o) |-> (!io_en_o && !$past(io_en_o)));
  p_removal_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!card_present_i && active_o) |=> !active_o);
  p_vcc_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vcc_en_o && !clk_tick_i) |=> vcc_en_o);
  p_clk_hold_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clk_en_o && !clk_tick_i) |=> clk_en_o);
endmodule

bind card_act_seq card_act_chk #(.RST_HOLD(RST_HOLD)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .card_present_i (card_present_i),
  .clk_tick_i     (clk_tick_i),
  .vcc_en_o       (vcc_en_o),
  .io_en_o        (io_en_o),
  .clk_en_o       (clk_en_o),
  .rst_o          (rst_o),
  .active_o       (active_o),
  .no_answer_o    (no_answer_o)
);

// File: tb/sim_card_act_seq.sv
`timescale 1ns/1ps
module sim_card_act_seq;
  localparam int HOLD = 20;
  localparam int AMIN = 5;
  localparam int AMAX = 30;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic card = 1'b0, act = 1'b0, deact = 1'b0, tick = 1'b0, sd = 1'b0;
  logic vcc, io, cke, crst, actv, nans, early;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  card_act_seq #(.RST_HOLD(HOLD), .ATR_MIN(AMIN), .ATR_MAX(AMAX)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .card_present_i(card), .activate_i(act),
    .deactivate_i(deact), .clk_tick_i(tick), .start_det_i(sd),
    .vcc_en_o(vcc), .io_en_o(io), .clk_en_o(cke), .rst_o(crst),
    .active_o(actv), .no_answer_o(nans), .early_answer_o(early)
  );

  wire [6:0] outv = {vcc, io, cke, crst, actv, nans, early};

  function automatic bit exp_active(int p);
    return (p >= AMIN) && (p < AMAX);
  endfunction
  function automatic bit exp_early(int p);
    return p < AMIN;
  endfunction

  task automatic chk(string req, logic [6:0] exp);
    checks++;
    if (outv !== exp) begin
      errors++;
      $display("FAIL %s outputs got %b expected %b", req, outv, exp);
    end
  endtask

  task automatic cyc(bit tk, bit s);
    tick = tk; sd = s;
    @(posedge clk); #1;
    tick = 1'b0; sd = 1'b0; act = 1'b0; deact = 1'b0;
  endtask

  task automatic gap();
    logic [6:0] snap;
    int n;
    snap = outv;
    n = $urandom_range(0, 2);
    if (n > 0) begin
      repeat (n) cyc(1'b0, 1'b0);
      chk("R13", snap);
    end
  endtask

  task automatic tick1(bit s);
    gap();
    cyc(1'b1, s);
  endtask

  task automatic power_up();
    act = 1'b1; cyc(1'b0, 1'b0);
    chk("R3 R11", 7'b1000000);
    tick1(1'b0); chk("R3", 7'b1100000);
    tick1(1'b0); chk("R3", 7'b1110000);
    for (int k = 1; k < HOLD; k++) tick1(1'($urandom_range(0, 1)));
    chk("R4 R12", 7'b1110000);
    tick1(1'b0); chk("R4", 7'b1111000);
  endtask

  task automatic deact_seq(string req, bit n, bit e);
    chk(req, {5'b11100, n, e});
    tick1(1'b0); chk("R8", {5'b11000, n, e});
    tick1(1'b0); chk("R8", {5'b10000, n, e});
    tick1(1'b0); chk("R8", {5'b00000, n, e});
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    cyc(1'b0, 1'b0);
    chk("R1", 7'b0000000);

    // R2: no card, request ignored
    act = 1'b1; cyc(1'b1, 1'b0);
    chk("R2", 7'b0000000);
    card = 1'b1;

    // R5 lower boundary, R12 edge while active, R9 request
    power_up();
    for (int k = 0; k < AMIN; k++) tick1(1'b0);
    cyc(1'b0, 1'b1); chk("R5", 7'b1111100);
    cyc(1'b1, 1'b1); chk("R12", 7'b1111100);
    deact = 1'b1; cyc(1'b0, 1'b0);
    deact_seq("R9", 1'b0, 1'b0);

    // R6 early then legal
    power_up();
    for (int k = 0; k < AMIN - 1; k++) tick1(1'b0);
    cyc(1'b0, 1'b1); chk("R6", 7'b1111001);
    tick1(1'b0);
    cyc(1'b0, 1'b1); chk("R6", 7'b1111101);
    deact = 1'b1; cyc(1'b0, 1'b0);
    deact_seq("R9", 1'b0, 1'b1);

    // R5 upper boundary, edge on closing tick
    power_up();
    for (int k = 0; k < AMAX - 1; k++) tick1(1'b0);
    cyc(1'b1, 1'b1); chk("R5 R7", 7'b1111100);
    deact = 1'b1; cyc(1'b0, 1'b0);
    deact_seq("R9", 1'b0, 1'b0);

    // R7 timeout
    power_up();
    for (int k = 0; k < AMAX - 1; k++) tick1(1'b0);
    chk("R7", 7'b1111000);
    tick1(1'b0);
    deact_seq("R7", 1'b1, 1'b0);

    // R11 flags clear, R10 removal during window
    power_up();
    for (int k = 0; k < 3; k++) tick1(1'b0);
    card = 1'b0; cyc(1'b0, 1'b0);
    deact_seq("R10", 1'b0, 1'b0);
    card = 1'b1;

    // R10 removal right after supply on
    act = 1'b1; cyc(1'b0, 1'b0); chk("R3", 7'b1000000);
    card = 1'b0; cyc(1'b0, 1'b0); chk("R10", 7'b1000000);
    tick1(1'b0); tick1(1'b0); chk("R8", 7'b1000000);
    tick1(1'b0); chk("R10", 7'b0000000);
    card = 1'b1;

    // random answer positions
    for (int it = 0; it < 10; it++) begin
      int p;
      p = $urandom_range(0, AMAX + 2);
      power_up();
      if (p >= AMAX) begin
        for (int k = 0; k < AMAX; k++) tick1(1'b0);
        deact_seq("R7", 1'b1, 1'b0);
      end else begin
        for (int k = 0; k < p; k++) tick1(1'b0);
        cyc(1'b0, 1'b1);
        chk(exp_active(p) ? "R5" : "R6",
            {4'b1111, exp_active(p), 1'b0, exp_early(p)});
        deact = 1'b1; cyc(1'b0, 1'b0);
        deact_seq("R9", 1'b0, exp_early(p));
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule